// File: doc/BRIEF.md
# Bridge Read Termination Translator

This block sits on the initiator side of a bridge between a local system bus and a PCI-style remote bus. It takes a single-word or fixed-length burst read from the local side and starts a remote transaction with a start address and a word count. It then follows the remote bus until that transaction terminates. Each way the remote bus can end a transaction becomes one local response. The response is a completion pulse that carries a read-error flag and a discard decision. The block can also issue a new remote transaction by itself, and it raises a one-cycle interrupt pulse for each kind of fault.

The data buffer is not part of this block. A prefetch word counter stands in for it. The counter is loaded with the burst length. It tells the block whether more words are still owed and at which word address the next remote transaction must start. Automatic retries are limited by a programmable count. When that count is used up, the read ends as if no target had responded. Every burst beat is checked against a fixed address window. A beat that would push the next address past the top of the window stops the transfer.

Top module: `rd_term_xlate`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `done_o`, `rd_err_o`, `discard_o`, `rem_start_o`, `rem_stop_o` and all four interrupt outputs are 0.
- R2: One cycle after a request is accepted (`req_valid_i` high while `req_ready_o` is high), `rem_start_o` pulses for one cycle. During that pulse, `rem_addr_o` equals the request word address, `rem_burst_o` equals `req_burst_i`, and `rem_cnt_o` is `req_len_i`+1 for a burst or 1 for a single read.
- R3: Suppose the remote bus ends with a completion-class code and no words remain owed. The completion-class codes are 0 (normal end), 1 (retry), 2 (disconnect) and 3 (latency-timer expiry). In the cycle after that end, `done_o` pulses with `rd_err_o`=0. `discard_o` is 0 unless R9 applies. `rd_err_o` and `discard_o` are never high without `done_o`.
- R4: A system-error end (code 6) at any point gives `done_o`, `rd_err_o`=1, `discard_o`=1 and an `irq_serr_o` pulse, all in the same cycle. This holds for both single and burst reads.
- R5: A no-response end (code 4, and reserved code 7) gives `done_o` with `rd_err_o`=1 and `discard_o`=1, and raises no interrupt.
- R6: Suppose a completion-class end arrives after no data word in the current remote transaction, and words are still owed. The block then re-issues the same address and count on its own: `rem_start_o` pulses in the next cycle and `done_o` stays 0.
- R7: Every automatic retry is counted for the current local read. If a retry arrives when the count already equals `retry_lim_i`, the read ends as in R5.
- R8: Suppose a completion-class end arrives after at least one data word, and words are still owed. This covers a disconnect with data and a latency-timer expiry. A new remote transaction then starts in the next cycle, at the next word address, with `rem_cnt_o` equal to the words still owed.
- R9: A data beat with `rem_perr_i` high gives an `irq_perr_o` pulse in the next cycle. The pulse happens at most once per local read. A single read then completes with `discard_o`=0 and `rd_err_o`=0. A burst completes with `discard_o`=1 and `rd_err_o`=0.
- R10: A target-abort end (code 5) gives `done_o` with `rd_err_o`=1 and an `irq_tabort_o` pulse. `discard_o` is 1 for a burst and 0 for a single read.
- R11: Suppose a burst beat leaves words still owed and the next word address would be above `WIN_HI`. In the following cycle, `rem_stop_o`, `irq_ovr_o` and `done_o` pulse together, with `rd_err_o`=1 and `discard_o`=0.
- R12: Every interrupt output is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retry_lim_i | input | RW | Maximum automatic retries per local read |
| req_valid_i | input | 1 | Local read request |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | AW | Local read start word address |
| req_burst_i | input | 1 | 1 = fixed-length burst, 0 = single word |
| req_len_i | input | LW | Burst length minus one, in words |
| rem_start_o | output | 1 | Start a remote read transaction |
| rem_addr_o | output | AW | Remote start word address |
| rem_cnt_o | output | LW+1 | Words to fetch in the remote transaction |
| rem_burst_o | output | 1 | Remote transaction is part of a burst |
| rem_stop_o | output | 1 | Stop the remote transaction (window overrun) |
| rem_beat_i | input | 1 | One data word received from the remote bus |
| rem_perr_i | input | 1 | Data parity error on this beat |
| rem_end_i | input | 1 | Remote transaction terminated |
| rem_term_i | input | 3 | Termination code, valid with rem_end_i |
| done_o | output | 1 | Local read complete (data acknowledge) |
| rd_err_o | output | 1 | Local read error, valid with done_o |
| discard_o | output | 1 | Buffered data discarded, valid with done_o |
| irq_serr_o | output | 1 | System error interrupt pulse |
| irq_perr_o | output | 1 | Data parity interrupt pulse |
| irq_tabort_o | output | 1 | Target abort interrupt pulse |
| irq_ovr_o | output | 1 | Address window overrun interrupt pulse |

## Verification
A corrupted prefetch counter or address register shows up at the ports on the next re-issue. It can also show up when the block completes: a re-issue then carries the wrong `rem_addr_o` or `rem_cnt_o`, or a completion arrives while words are still owed, or no completion arrives when none are owed. A retry counter that is off by one ends a read as a no-response error one retry too early or too late, and this is visible on the retry where the limit is reached. A sticky parity flag that fails to set, or fails to clear between reads, shows in the same cycle as `done_o`. It appears either as a second `irq_perr_o` pulse or as a wrong `discard_o` on the completion of that read or of the next one.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  typedef enum logic [2:0] {
    TERM_NORMAL = 3'd0,
    TERM_RETRY  = 3'd1,
    TERM_DISC   = 3'd2,
    TERM_LATEXP = 3'd3,
    TERM_NORESP = 3'd4,
    TERM_TGTABT = 3'd5,
    TERM_SYSERR = 3'd6,
    TERM_RSVD   = 3'd7
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;
endpackage

// File: rtl/rdx_fetch_track.sv
module rdx_fetch_track #(
  parameter int unsigned AW     = 16,
  parameter int unsigned CW     = 5,
  parameter int unsigned WIN_HI = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          issue_i,
  input  logic          beat_i,
  input  logic          burst_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] left_o,
  output logic [CW-1:0] left_nxt_o,
  output logic          got_any_o,
  output logic          ovr_o
);
  localparam logic [AW:0] HI_EXT = (AW+1)'(WIN_HI);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic          got_q;
  logic [AW:0]   addr_inc;

  assign left_nxt_o = (beat_i && left_q != '0) ? left_q - 1'b1 : left_q;
  assign addr_inc   = {1'b0, addr_q} + 1'b1;
  // beat that leaves words owed and steps past the window top
  assign ovr_o      = burst_i && beat_i && (left_nxt_o != '0) && (addr_inc > HI_EXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      got_q  <= 1'b0;
    end else if (load_i) begin
      addr_q <= addr_i;
      left_q <= cnt_i;
      got_q  <= 1'b0;
    end else begin
      if (issue_i) got_q <= 1'b0;
      if (beat_i) begin
        addr_q <= addr_inc[AW-1:0];
        left_q <= left_nxt_o;
        got_q  <= 1'b1;
      end
    end
  end

  assign addr_o    = addr_q;
  assign left_o    = left_q;
  assign got_any_o = got_q;

  AST_BEAT_OWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> left_q != '0); // R3
endmodule

// File: rtl/rdx_retry_ctr.sv
module rdx_retry_ctr #(
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [RW-1:0] lim_i,
  output logic          hit_o
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = cnt_q >= lim_i;

  AST_NO_INC_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !hit_o); // R7
endmodule

// File: rtl/rd_term_xlate.sv
module rd_term_xlate #(
  parameter int unsigned AW     = 16,
  parameter int unsigned LW     = 4,
  parameter int unsigned RW     = 4,
  parameter int unsigned WIN_HI = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] retry_lim_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_burst_i,
  input  logic [LW-1:0] req_len_i,
  output logic          rem_start_o,
  output logic [AW-1:0] rem_addr_o,
  output logic [LW:0]   rem_cnt_o,
  output logic          rem_burst_o,
  output logic          rem_stop_o,
  input  logic          rem_beat_i,
  input  logic          rem_perr_i,
  input  logic          rem_end_i,
  input  logic [2:0]    rem_term_i,
  output logic          done_o,
  output logic          rd_err_o,
  output logic          discard_o,
  output logic          irq_serr_o,
  output logic          irq_perr_o,
  output logic          irq_tabort_o,
  output logic          irq_ovr_o
);
  import rdx_pkg::*;

  localparam int unsigned CW = LW + 1;

  st_e           st_q;
  logic          burst_q, perr_seen_q;
  logic          done_q, err_q, disc_q, stop_q;
  logic          irq_serr_q, irq_perr_q, irq_tab_q, irq_ovr_q;
  logic          load, issue, beat, perr_now;
  logic [CW-1:0] load_cnt, left, left_nxt;
  logic [AW-1:0] cur_addr;
  logic          got_any, ovr, hit, cmpl_class, no_data, retry_inc;
  term_e         term;

  assign load     = (st_q == ST_IDLE) && req_valid_i;
  assign issue    = (st_q == ST_ISSUE);
  assign beat     = (st_q == ST_WAIT) && rem_beat_i;
  assign load_cnt = req_burst_i ? CW'(req_len_i) + 1'b1 : CW'(1);
  assign term     = term_e'(rem_term_i);
  assign perr_now = perr_seen_q || (beat && rem_perr_i);

  rdx_fetch_track #(.AW(AW), .CW(CW), .WIN_HI(WIN_HI)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .addr_i     (req_addr_i),
    .cnt_i      (load_cnt),
    .issue_i    (issue),
    .beat_i     (beat),
    .burst_i    (burst_q),
    .addr_o     (cur_addr),
    .left_o     (left),
    .left_nxt_o (left_nxt),
    .got_any_o  (got_any),
    .ovr_o      (ovr)
  );

  always_comb begin
    cmpl_class = 1'b0;
    unique case (term)
      TERM_NORMAL, TERM_RETRY, TERM_DISC, TERM_LATEXP: cmpl_class = 1'b1;
      default: cmpl_class = 1'b0;
    endcase
  end

  assign no_data   = !got_any && !beat;
  assign retry_inc = (st_q == ST_WAIT) && rem_end_i && !ovr && cmpl_class &&
                     (left_nxt != '0) && no_data && !hit;

  rdx_retry_ctr #(.RW(RW)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .inc_i  (retry_inc),
    .lim_i  (retry_lim_i),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      burst_q     <= 1'b0;
      perr_seen_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      disc_q      <= 1'b0;
      stop_q      <= 1'b0;
      irq_serr_q  <= 1'b0;
      irq_perr_q  <= 1'b0;
      irq_tab_q   <= 1'b0;
      irq_ovr_q   <= 1'b0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      disc_q     <= 1'b0;
      stop_q     <= 1'b0;
      irq_serr_q <= 1'b0;
      irq_perr_q <= 1'b0;
      irq_tab_q  <= 1'b0;
      irq_ovr_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q        <= ST_ISSUE;
          burst_q     <= req_burst_i;
          perr_seen_q <= 1'b0;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        default: begin
          if (beat && rem_perr_i && !perr_seen_q) begin
            perr_seen_q <= 1'b1;
            irq_perr_q  <= 1'b1;
          end
          if (ovr) begin
            st_q      <= ST_IDLE;
            done_q    <= 1'b1;
            err_q     <= 1'b1;
            stop_q    <= 1'b1;
            irq_ovr_q <= 1'b1;
          end else if (rem_end_i) begin
            if (cmpl_class) begin
              if (left_nxt == '0) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                disc_q <= burst_q && perr_now;
              end else if (no_data && hit) begin
                // retry budget spent: end as no-response
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b1;
                disc_q <= 1'b1;
              end else begin
                st_q <= ST_ISSUE;
              end
            end else begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
              unique case (term)
                TERM_TGTABT: begin
                  disc_q    <= burst_q;
                  irq_tab_q <= 1'b1;
                end
                TERM_SYSERR: begin
                  disc_q     <= 1'b1;
                  irq_serr_q <= 1'b1;
                end
                default: disc_q <= 1'b1;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign rem_start_o  = issue;
  assign rem_addr_o   = cur_addr;
  assign rem_cnt_o    = left;
  assign rem_burst_o  = burst_q;
  assign rem_stop_o   = stop_q;
  assign done_o       = done_q;
  assign rd_err_o     = err_q;
  assign discard_o    = disc_q;
  assign irq_serr_o   = irq_serr_q;
  assign irq_perr_o   = irq_perr_q;
  assign irq_tabort_o = irq_tab_q;
  assign irq_ovr_o    = irq_ovr_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_start_o |=> !rem_start_o); // R2
  AST_START_CNT_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_start_o |-> rem_cnt_o != '0); // R2
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_err_o || discard_o) |-> done_o); // R3
  AST_SERR_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_serr_o |-> (done_o && rd_err_o && discard_o)); // R4
  AST_PERR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_perr_o |=> !irq_perr_o); // R9
  AST_TAB_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tabort_o |-> (done_o && rd_err_o)); // R10
  AST_OVR_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_stop_o |-> (irq_ovr_o && done_o && rd_err_o && !discard_o)); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_serr_o || irq_tabort_o || irq_ovr_o) |=> !(irq_serr_o || irq_tabort_o || irq_ovr_o)); // R12
endmodule

// File: tb/rd_term_xlate_test.sv
module rd_term_xlate_test;
  localparam int AW = 16, LW = 4, RW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [RW-1:0] retry_lim_i = 4'd3;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_burst_i = 1'b0;
  logic [LW-1:0] req_len_i = '0;
  logic          rem_start_o;
  logic [AW-1:0] rem_addr_o;
  logic [LW:0]   rem_cnt_o;
  logic          rem_burst_o, rem_stop_o;
  logic          rem_beat_i = 1'b0, rem_perr_i = 1'b0, rem_end_i = 1'b0;
  logic [2:0]    rem_term_i = 3'd0;
  logic          done_o, rd_err_o, discard_o;
  logic          irq_serr_o, irq_perr_o, irq_tabort_o, irq_ovr_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rd_term_xlate uut (
    .clk_i(clk), .rst_ni(rst_ni), .retry_lim_i(retry_lim_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .req_burst_i(req_burst_i), .req_len_i(req_len_i),
    .rem_start_o(rem_start_o), .rem_addr_o(rem_addr_o), .rem_cnt_o(rem_cnt_o),
    .rem_burst_o(rem_burst_o), .rem_stop_o(rem_stop_o),
    .rem_beat_i(rem_beat_i), .rem_perr_i(rem_perr_i), .rem_end_i(rem_end_i),
    .rem_term_i(rem_term_i),
    .done_o(done_o), .rd_err_o(rd_err_o), .discard_o(discard_o),
    .irq_serr_o(irq_serr_o), .irq_perr_o(irq_perr_o),
    .irq_tabort_o(irq_tabort_o), .irq_ovr_o(irq_ovr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // {done, err, discard}
  function automatic logic [2:0] resp();
    return {done_o, rd_err_o, discard_o};
  endfunction

  function automatic logic [3:0] irqs();
    return {irq_serr_o, irq_perr_o, irq_tabort_o, irq_ovr_o};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic req(input logic [AW-1:0] a, input logic b, input logic [LW-1:0] l, input string tag);
    chk({tag, " R2 ready"}, req_ready_o, 1'b1);
    req_addr_i = a; req_burst_i = b; req_len_i = l; req_valid_i = 1'b1;
    cyc();
    req_valid_i = 1'b0;
    chk({tag, " R2 start"}, rem_start_o, 1'b1);
    chk({tag, " R2 addr"}, rem_addr_o, a);
    chk({tag, " R2 cnt"}, rem_cnt_o, b ? l + 1 : 1);
    chk({tag, " R2 burst"}, rem_burst_o, b);
    cyc();
  endtask

  task automatic beat(input logic p);
    rem_beat_i = 1'b1; rem_perr_i = p;
    cyc();
    rem_beat_i = 1'b0; rem_perr_i = 1'b0;
  endtask

  task automatic term(input logic [2:0] c);
    rem_end_i = 1'b1; rem_term_i = c;
    cyc();
    rem_end_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", req_ready_o, 1'b1);
    chk("R1 resp", resp(), 3'b000);
    chk("R1 irqs", irqs(), 4'b0000);
    chk("R1 remote", {rem_start_o, rem_stop_o}, 2'b00);
  endtask

  task automatic t_single_ok();
    req(16'h0010, 1'b0, 4'd0, "single");
    beat(1'b0);
    chk("R3 no early done", done_o, 1'b0);
    term(3'd0);
    chk("R3 single resp", resp(), 3'b100);
    chk("R3 single irqs", irqs(), 4'b0000);
    cyc();
    chk("R3 done pulse", done_o, 1'b0);
  endtask

  task automatic t_burst_ok();
    req(16'h0020, 1'b1, 4'd3, "burst");
    for (int i = 0; i < 4; i++) beat(1'b0);
    term(3'd0);
    chk("R3 burst resp", resp(), 3'b100);
  endtask

  task automatic t_serr();
    req(16'h0050, 1'b1, 4'd3, "serr");
    beat(1'b0);
    term(3'd6);
    chk("R4 serr resp", resp(), 3'b111);
    chk("R4 serr irq", irqs(), 4'b1000);
    cyc();
    chk("R12 serr pulse", irqs(), 4'b0000);
    req(16'h0058, 1'b0, 4'd0, "serr single");
    term(3'd6);
    chk("R4 serr single resp", resp(), 3'b111);
  endtask

  task automatic t_noresp();
    req(16'h0060, 1'b0, 4'd0, "noresp");
    term(3'd4);
    chk("R5 noresp resp", resp(), 3'b111);
    chk("R5 noresp irqs", irqs(), 4'b0000);
    req(16'h0061, 1'b1, 4'd1, "rsvd");
    term(3'd7);
    chk("R5 reserved code resp", resp(), 3'b111);
  endtask

  task automatic t_retry();
    retry_lim_i = 4'd3;
    req(16'h0070, 1'b1, 4'd1, "retry");
    term(3'd1);
    chk("R6 restart", rem_start_o, 1'b1);
    chk("R6 same addr", rem_addr_o, 16'h0070);
    chk("R6 same cnt", rem_cnt_o, 5'd2);
    chk("R6 no done", done_o, 1'b0);
    cyc();
    beat(1'b0); beat(1'b0);
    term(3'd0);
    chk("R6 after retry resp", resp(), 3'b100);
  endtask

  task automatic t_retry_limit();
    retry_lim_i = 4'd1;
    req(16'h0030, 1'b0, 4'd0, "limit");
    term(3'd1);
    chk("R7 first retry allowed", rem_start_o, 1'b1);
    cyc();
    term(3'd1);
    chk("R7 limit ends read", resp(), 3'b111);
    chk("R7 no restart", rem_start_o, 1'b0);
    retry_lim_i = 4'd0;
    req(16'h0031, 1'b0, 4'd0, "limit0");
    term(3'd1);
    chk("R7 zero limit", resp(), 3'b111);
    retry_lim_i = 4'd3;
  endtask

  task automatic t_disc_data();
    req(16'h0040, 1'b1, 4'd3, "disc");
    beat(1'b0); beat(1'b0);
    term(3'd2);
    chk("R8 disc restart", rem_start_o, 1'b1);
    chk("R8 disc addr", rem_addr_o, 16'h0042);
    chk("R8 disc cnt", rem_cnt_o, 5'd2);
    chk("R8 disc no done", done_o, 1'b0);
    cyc();
    beat(1'b0);
    term(3'd3);
    chk("R8 lat restart", rem_start_o, 1'b1);
    chk("R8 lat addr", rem_addr_o, 16'h0043);
    chk("R8 lat cnt", rem_cnt_o, 5'd1);
    cyc();
    beat(1'b0);
    term(3'd3);
    chk("R8 lat end done", resp(), 3'b100);
  endtask

  task automatic t_perr();
    req(16'h0080, 1'b0, 4'd0, "perr single");
    beat(1'b1);
    chk("R9 single irq", irq_perr_o, 1'b1);
    term(3'd0);
    chk("R9 single keeps data", resp(), 3'b100);
    chk("R12 perr pulse", irq_perr_o, 1'b0);
    req(16'h0090, 1'b1, 4'd1, "perr burst");
    beat(1'b1);
    chk("R9 burst irq", irq_perr_o, 1'b1);
    beat(1'b1);
    chk("R9 once per read", irq_perr_o, 1'b0);
    term(3'd0);
    chk("R9 burst discards", resp(), 3'b101);
    req(16'h00A0, 1'b1, 4'd0, "perr cleared");
    beat(1'b0);
    term(3'd0);
    chk("R9 flag cleared per read", resp(), 3'b100);
  endtask

  task automatic t_tabort();
    req(16'h00B0, 1'b0, 4'd0, "tab single");
    term(3'd5);
    chk("R10 single resp", resp(), 3'b110);
    chk("R10 single irq", irqs(), 4'b0010);
    req(16'h00B8, 1'b1, 4'd3, "tab burst");
    beat(1'b0);
    term(3'd5);
    chk("R10 burst resp", resp(), 3'b111);
    cyc();
    chk("R12 tab pulse", irqs(), 4'b0000);
  endtask

  task automatic t_overrun();
    req(16'h00FE, 1'b1, 4'd3, "ovr");
    beat(1'b0);
    chk("R11 inside window", {done_o, rem_stop_o}, 2'b00);
    beat(1'b0);
    chk("R11 resp", resp(), 3'b110);
    chk("R11 stop", rem_stop_o, 1'b1);
    chk("R11 irq", irqs(), 4'b0001);
    cyc();
    chk("R12 ovr pulse", {irq_ovr_o, rem_stop_o}, 2'b00);
    req(16'h00FF, 1'b0, 4'd0, "ovr single");
    beat(1'b0);
    term(3'd0);
    chk("R11 single at top no overrun", {resp(), irq_ovr_o}, 4'b1000);
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    t_reset();
    t_single_ok();
    t_burst_ok();
    t_serr();
    t_noresp();
    t_retry();
    t_retry_limit();
    t_disc_data();
    t_perr();
    t_tabort();
    t_overrun();
    repeat (2) cyc();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule